// File: doc/BRIEF.md
# Multi-Index Effective Address Unit

This block turns an instruction's address field into an operand's effective address. It holds a small bank of index registers, which are loaded through a write port. Two select slots in the instruction name which index registers take part. A slot value of zero means that slot adds no index.

The selected indices are merged in one of two ways, chosen by a configuration input. They are either added together or bitwise ORed together. The merged index is then added to the base address, or subtracted from it when the instruction's direction bit is set. The base address comes from the immediate field or from an external register, chosen by a source-select input.

The result is registered. It is presented together with a one-cycle valid strobe on the cycle after the request.

Top module: `idx_ea_unit`

## Requirements
- R1: After reset, `ea_valid` is 0, `ea` is 0, and all three index registers hold 0.
- R2: `ea_valid` is 1 in exactly the cycle after each cycle in which `req` is 1, and 0 otherwise.
- R3: A select slot value of 0 contributes no index. A value k of 1, 2 or 3 selects index register k.
- R4: With `or_mode` = 0 and `sub` = 0, `ea` = base + idx(`sel_a`) + idx(`sel_b`) modulo 2^15. Carries out of bit 14 are dropped.
- R5: With `or_mode` = 1, the merged index is idx(`sel_a`) | idx(`sel_b`) instead of their sum.
- R6: With `sub` = 1, `ea` = base − merged index modulo 2^15.
- R7: The base is `base_imm` when `base_src` = 0 and `base_reg` when `base_src` = 1.
- R8: A request in the same cycle as a write to an index register it selects uses that register's old value. Later requests see the new value.
- R9: A write with `wr_sel` = 0 changes no index register.
- R10: `ea` holds its value in cycles after which no request was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Index register write enable |
| wr_sel | input | 2 | Register to write (1..3; 0 writes nothing) |
| wr_data | input | 15 | Value to write |
| req | input | 1 | Address request |
| base_imm | input | 15 | Address field from the instruction |
| base_reg | input | 15 | Base taken from another register |
| base_src | input | 1 | 0 selects base_imm, 1 selects base_reg |
| sel_a | input | 2 | First index select slot |
| sel_b | input | 2 | Second index select slot |
| sub | input | 1 | 1 subtracts the index from the base |
| or_mode | input | 1 | 1 merges the selected indices by OR, 0 by sum |
| ea | output | 15 | Effective address |
| ea_valid | output | 1 | High for one cycle when ea is new |

## Verification
Every result of this block is due one clock edge after the request that caused it:
- `ea` and `ea_valid` appear after that edge.
- The hold of `ea` and the drop of `ea_valid` show after the following idle edge.

The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. Each check therefore sees exactly one register stage.

A write takes effect at the same edge as a request made in that cycle. The bench computes that request's expected value from its shadow copy before the edge, and updates the shadow only afterwards.

// File: rtl/idx_ea_unit.sv
module idx_ea_unit #(
  parameter int AW   = 15,
  parameter int NIDX = 3,
  parameter int SELW = $clog2(NIDX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [AW-1:0]   wr_data,
  input  logic            req,
  input  logic [AW-1:0]   base_imm,
  input  logic [AW-1:0]   base_reg,
  input  logic            base_src,
  input  logic [SELW-1:0] sel_a,
  input  logic [SELW-1:0] sel_b,
  input  logic            sub,
  input  logic            or_mode,
  output logic [AW-1:0]   ea,
  output logic            ea_valid
);

  logic [AW-1:0] xr [NIDX];
  logic [AW-1:0] ia, ib, merged, base, ea_nxt;

  function automatic logic [AW-1:0] pick(input logic [SELW-1:0] s,
                                         input logic [AW-1:0] r [NIDX]);
    logic [AW-1:0] v;
    v = '0;
    for (int i = 0; i < NIDX; i++)
      if (s == SELW'(i + 1)) v = r[i];
    return v;
  endfunction

  assign ia     = pick(sel_a, xr);
  assign ib     = pick(sel_b, xr);
  assign merged = or_mode ? (ia | ib) : (ia + ib);
  assign base   = base_src ? base_reg : base_imm;
  assign ea_nxt = sub ? (base - merged) : (base + merged);

  for (genvar g = 0; g < NIDX; g++) begin : g_idx
    always_ff @(posedge clk) begin
      if (!rst_n)                                  xr[g] <= '0;
      else if (wr_en && wr_sel == SELW'(g + 1))    xr[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea       <= '0;
      ea_valid <= 1'b0;
    end else begin
      ea_valid <= req;
      if (req) ea <= ea_nxt;
    end
  end

endmodule

// File: rtl/idx_ea_unit_chk.sv
module idx_ea_unit_chk #(
  parameter int AW   = 15,
  parameter int SELW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic [AW-1:0]   base_imm,
  input logic [AW-1:0]   base_reg,
  input logic            base_src,
  input logic [SELW-1:0] sel_a,
  input logic [SELW-1:0] sel_b,
  input logic [AW-1:0]   ea,
  input logic            ea_valid
);

  // R2
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ea_valid);

  // R2
  no_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !ea_valid);

  // R10
  ea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(ea));

  // R3
  zero_slot_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sel_a == '0 && sel_b == '0 && !base_src) |=> ea == $past(base_imm));

  // R7
  zero_slot_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sel_a == '0 && sel_b == '0 && base_src) |=> ea == $past(base_reg));

endmodule

bind idx_ea_unit idx_ea_unit_chk #(.AW(AW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .base_imm(base_imm),
  .base_reg(base_reg), .base_src(base_src), .sel_a(sel_a), .sel_b(sel_b),
  .ea(ea), .ea_valid(ea_valid)
);

// File: tb/tb_idx_ea_unit.sv
`timescale 1ns/1ps
module tb_idx_ea_unit;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [1:0] wr_sel = 0; logic [14:0] wr_data = 0;
  logic req = 0; logic [14:0] base_imm = 0, base_reg = 0; logic base_src = 0;
  logic [1:0] sel_a = 0, sel_b = 0; logic sub = 0, or_mode = 0;
  logic [14:0] ea; logic ea_valid;

  int nchk = 0, nfail = 0;
  logic [14:0] xm [4];

  always #2 clk = ~clk;

  idx_ea_unit dut (.*);

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [14:0] model(input logic [14:0] bi, br, input logic bs,
      input logic [1:0] a, b, input logic sb, om);
    logic [14:0] ix, bse;
    ix  = om ? (xm[a] | xm[b]) : 15'(xm[a] + xm[b]);
    bse = bs ? br : bi;
    return sb ? 15'(bse - ix) : 15'(bse + ix);
  endfunction

  task automatic wr(input logic [1:0] s, input logic [14:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    if (s != 0) xm[s] = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic go(input string rq, input logic [14:0] bi, br, input logic bs,
      input logic [1:0] a, b, input logic sb, om);
    logic [14:0] e;
    @(negedge clk);
    req = 1; base_imm = bi; base_reg = br; base_src = bs;
    sel_a = a; sel_b = b; sub = sb; or_mode = om;
    e = model(bi, br, bs, a, b, sb, om);
    @(posedge clk); #1;
    chk({rq, " valid"}, ea_valid, 1);
    chk(rq, ea, e);
  endtask

  task automatic idle(input string rq);
    logic [14:0] prev;
    @(negedge clk); req = 0; prev = ea; base_imm = 15'h5A5A; sel_a = 1;
    @(posedge clk); #1;
    chk({rq, " valid low"}, ea_valid, 0);
    chk({rq, " ea hold"}, ea, prev);
  endtask

  task automatic t_reset;
    chk("R1 valid", ea_valid, 0);
    chk("R1 ea", ea, 0);
    go("R1 regs zero", 15'h0064, 0, 0, 1, 2, 0, 0);
    go("R1 reg3 zero", 15'h0123, 0, 0, 3, 3, 0, 0);
    idle("R2/R10");
  endtask

  task automatic t_sum;
    wr(1, 15'h0013); wr(2, 15'h0203); wr(3, 15'h7000);
    go("R4 sum", 15'h1000, 0, 0, 1, 2, 0, 0);
    chk("R4 literal", ea, 15'h1216);
    go("R3 slot a zero", 15'h0040, 0, 0, 0, 3, 0, 0);
    go("R3 slot b zero", 15'h0040, 0, 0, 2, 0, 0, 0);
    go("R4 wrap", 15'h2000, 0, 0, 3, 3, 0, 0);
    chk("R4 wrap literal", ea, 15'h0000);
    idle("R2/R10 after sum");
  endtask

  task automatic t_or;
    go("R5 or", 15'h1000, 0, 0, 1, 2, 0, 1);
    chk("R5 literal", ea, 15'h1213);
    go("R5 or same reg", 15'h0001, 0, 0, 3, 3, 0, 1);
    chk("R5 same reg literal", ea, 15'h7001);
    idle("R2 after or");
  endtask

  task automatic t_sub;
    go("R6 sub", 15'h0100, 0, 0, 1, 0, 0, 0);
    go("R6 sub", 15'h0100, 0, 0, 1, 0, 1, 0);
    chk("R6 literal", ea, 15'h00ED);
    go("R6 sub wrap", 15'h0010, 0, 0, 0, 3, 1, 0);
    chk("R6 wrap literal", ea, 15'h1010);
    go("R6 sub or", 15'h4000, 0, 0, 1, 2, 1, 1);
    idle("R2 after sub");
  endtask

  task automatic t_src;
    go("R7 reg base", 15'h1111, 15'h0555, 1, 1, 0, 0, 0);
    chk("R7 literal", ea, 15'h0568);
    go("R7 imm base", 15'h1111, 15'h0555, 0, 0, 0, 0, 0);
    go("R7 reg only", 15'h1111, 15'h0555, 1, 0, 0, 0, 0);
    idle("R10 after src");
  endtask

  task automatic t_same_cycle;
    logic [14:0] e;
    @(negedge clk);
    wr_en = 1; wr_sel = 1; wr_data = 15'h0400;
    req = 1; base_imm = 15'h0100; base_src = 0; sel_a = 1; sel_b = 0; sub = 0; or_mode = 0;
    e = model(15'h0100, 0, 0, 1, 0, 0, 0);
    @(posedge clk); #1;
    xm[1] = 15'h0400;
    chk("R8 old value", ea, e);
    @(negedge clk); wr_en = 0;
    @(posedge clk); #1;
    chk("R8 new value", ea, 15'h0500);
    idle("R8 end");
  endtask

  task automatic t_wr0;
    wr(0, 15'h7FFF);
    go("R9 reg1", 0, 0, 0, 1, 0, 0, 0);
    go("R9 reg2", 0, 0, 0, 2, 0, 0, 0);
    go("R9 reg3", 0, 0, 0, 3, 0, 0, 0);
    idle("R9 end");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) xm[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    t_reset();
    t_sum();
    t_or();
    t_sub();
    t_src();
    t_same_cycle();
    t_wr0();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #100000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule